// File: doc/BRIEF.md
# Receive/Transmit FIFO Burst Access Window

This block gives a 32-bit host register bus bulk access to the receive and transmit FIFOs of a four-channel serial port. Each channel has a receive FIFO and a transmit FIFO, 256 entries each. Each receive entry holds a data byte and the line-status byte that was captured with it. Each transmit entry holds one byte. The serial engines push entries into the receive FIFOs and pop bytes from the transmit FIFOs through simple strobe ports. The host reaches the same FIFOs through address windows.

Each channel has a transfer window and a status window. A read of the transfer window drains receive data as packed bytes. A write to the transfer window loads the transmit FIFO with up to four bytes. A read of the status window drains receive entries two at a time, and each data byte comes back next to its own status byte in fixed lanes. Consecutive DWORD reads can drain a whole FIFO, one access per clock. The bus bridge supplies only the address bits above the window offset. The offset inside a window has no effect, so a burst with an incrementing address keeps hitting the same FIFO port.

Top module: `fifoBurstWindow`

## Requirements
- R1: `busPage` holds byte-address bits 15:8. Bits 7:4 must be zero. Bits 3:2 select the channel, which gives a channel stride of 0x400. Bits 1:0 select the window: 01 is the transfer window, 10 is the status window, and 00 and 11 are not claimed. `busHit` is high in the same cycle for any `busReq` in the transfer window, and for a read in the status window. A write to the status window is not claimed and has no effect.
- R2: Every claimed read returns `busRdata` with `busRvalid` high exactly one cycle later. Claimed reads may be issued on every consecutive cycle.
- R3: A transfer-window read fills its enabled byte lanes in ascending lane order with consecutive receive entries. The lowest enabled lane gets the oldest entry. Each byte returned pops one entry, and disabled lanes read 0x00.
- R4: A status-window read returns the oldest entry in bits 15:0 and the next entry in bits 31:16. Within each 16-bit half, the low byte is the status and the high byte is the data. A half takes part only when both of its byte enables are set. Each such half pops one entry, in ascending order.
- R5: In the status window, if either half has exactly one of its two byte enables set, the read returns 0x00000000 and pops nothing.
- R6: A read that covers more entries than the FIFO holds returns 0x00 in the lanes or halves that find no entry, and pops only the entries that exist.
- R7: A transfer-window write pushes its enabled byte lanes into the transmit FIFO in ascending lane order, starting with bits 7:0. `txPopData` shows the oldest byte of channel `txPopChan`, and `txEmpty` reports an empty FIFO per channel.
- R8: Bytes that find the transmit FIFO full are dropped, and the bytes before them in the same write are kept. The channel's `txOverflow` bit then goes high and stays high until reset.
- R9: A receive FIFO holds 256 entries. A push into a full receive FIFO is dropped. A full FIFO drains completely and in order through 64 consecutive packed reads.
- R10: After reset, `busRvalid` is low, every `txEmpty` bit is high, and every `txOverflow` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Host access request in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busPage | input | 8 | Byte-address bits 15:8 |
| busBe | input | 4 | Byte-lane enables |
| busWdata | input | 32 | Write data |
| busHit | output | 1 | Access claimed by this block |
| busRdata | output | 32 | Read data, one cycle after the request |
| busRvalid | output | 1 | Read data valid |
| rxPushEn | input | 1 | Serial engine receive push |
| rxPushChan | input | 2 | Channel of receive push |
| rxPushData | input | 8 | Received data byte |
| rxPushStat | input | 8 | Line status of that byte |
| txPopEn | input | 1 | Serial engine transmit pop |
| txPopChan | input | 2 | Channel of transmit pop and of `txPopData` |
| txPopData | output | 8 | Oldest transmit byte of `txPopChan` |
| txEmpty | output | 4 | Transmit FIFO empty, one bit per channel |
| txOverflow | output | 4 | Sticky transmit overflow, one bit per channel |

## Verification
The hardest case to reach is a host write that lands on the exact boundary of a full transmit FIFO, so that some lanes of one DWORD are kept and the rest are dropped. The bench builds this state with 63 full-word writes and one half-word write, which leaves two free slots. The next full-word write must then keep lanes 0 and 1 only, and the bench checks this by draining all 256 bytes in order. Partial reads that cross the empty point are reached the same way: the bench stocks a channel with fewer entries than one access covers, and mixes sparse and torn byte enables.

// File: rtl/fifoWinPkg.sv
package fifoWinPkg;
  localparam int LANES = 4;

  // control-to-datapath strobes for one host access
  typedef struct packed {
    logic            rdCapture;  // claimed read this cycle
    logic            statusView; // status window selected
    logic [3:0]      laneLive;   // lane receives an entry
    logic [3:0][1:0] laneEntry;  // offset of that entry from the head
    logic [2:0]      popCnt;     // receive entries consumed
    logic [2:0]      pushCnt;    // transmit bytes accepted
    logic [3:0][1:0] pushLane;   // source lane of the j-th pushed byte
    logic            ovfSet;     // at least one byte dropped
  } winStrobe_t;
endpackage

// File: rtl/chanFifo.sv
module chanFifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  parameter int NPUSH = 1,
  parameter int NPOP  = 1,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2:0]                 pushCnt,
  input  logic [NPUSH-1:0][W-1:0]    pushData,
  input  logic [2:0]                 popCnt,
  output logic [NPOP-1:0][W-1:0]     peek,
  output logic [CW-1:0]              level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    for (int j = 0; j < NPUSH; j++) begin
      if (3'(j) < pushCnt) mem[wrPtr + AW'(j)] <= pushData[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushCnt);
      rdPtr <= rdPtr + AW'(popCnt);
      level <= level + CW'(pushCnt) - CW'(popCnt);
    end
  end

  always_comb begin
    for (int j = 0; j < NPOP; j++) peek[j] = mem[rdPtr + AW'(j)];
  end
endmodule

// File: rtl/winCtrl.sv
module winCtrl
  import fifoWinPkg::*;
#(
  parameter int CH     = 4,
  parameter int DEPTH  = 256,
  parameter int PAGE_W = 8,
  parameter int CHW    = $clog2(CH),
  parameter int CW     = $clog2(DEPTH) + 1
) (
  input  logic                     busReq,
  input  logic                     busWr,
  input  logic [PAGE_W-1:0]        busPage,
  input  logic [3:0]               busBe,
  input  logic [CH-1:0][CW-1:0]    rxLevel,
  input  logic [CH-1:0][CW-1:0]    txLevel,
  output logic                     busHit,
  output logic [CHW-1:0]           chanSel,
  output winStrobe_t               st
);
  localparam int UPPER_LSB = 2 + CHW;

  logic [1:0]      winCode;
  logic            upperClear, xferWin, statWin, rdAcc, wrAcc;
  logic [CW-1:0]   rxAvail, txFree;
  logic [3:0][2:0] rank;
  logic            halfFull0, halfFull1, torn, live0, live1;
  logic [2:0]      statRank1;

  assign winCode    = busPage[1:0];
  assign chanSel    = busPage[2 +: CHW];
  assign upperClear = (busPage >> UPPER_LSB) == '0;
  assign xferWin    = winCode == 2'b01;
  assign statWin    = winCode == 2'b10;
  assign busHit     = busReq && upperClear && (xferWin || (statWin && !busWr));
  assign rdAcc      = busHit && !busWr;
  assign wrAcc      = busHit && busWr;
  assign rxAvail    = rxLevel[chanSel];
  assign txFree     = CW'(DEPTH) - txLevel[chanSel];

  // position of each enabled lane among the enabled lanes
  always_comb begin
    logic [2:0] run;
    run = 3'd0;
    for (int k = 0; k < 4; k++) begin
      rank[k] = run;
      if (busBe[k]) run = run + 3'd1;
    end
  end

  assign halfFull0 = busBe[1:0] == 2'b11;
  assign halfFull1 = busBe[3:2] == 2'b11;
  assign torn      = (busBe[1] ^ busBe[0]) || (busBe[3] ^ busBe[2]);
  assign statRank1 = halfFull0 ? 3'd1 : 3'd0;
  assign live0     = halfFull0 && !torn && (rxAvail != '0);
  assign live1     = halfFull1 && !torn && (CW'(statRank1) < rxAvail);

  always_comb begin
    logic [2:0] cnt;
    st = '0;
    cnt = 3'd0;
    st.rdCapture  = rdAcc;
    st.statusView = statWin;
    if (rdAcc && xferWin) begin
      for (int k = 0; k < 4; k++) begin
        st.laneEntry[k] = rank[k][1:0];
        if (busBe[k] && (CW'(rank[k]) < rxAvail)) begin
          st.laneLive[k] = 1'b1;
          cnt = cnt + 3'd1;
        end
      end
      st.popCnt = cnt;
    end else if (rdAcc && statWin) begin
      st.laneLive     = {live1, live1, live0, live0};
      st.laneEntry[0] = 2'd0;
      st.laneEntry[1] = 2'd0;
      st.laneEntry[2] = statRank1[1:0];
      st.laneEntry[3] = statRank1[1:0];
      st.popCnt       = {2'b00, live0} + {2'b00, live1};
    end
    if (wrAcc) begin
      for (int k = 0; k < 4; k++) begin
        if (busBe[k]) begin
          if (CW'(rank[k]) < txFree) begin
            st.pushLane[rank[k][1:0]] = 2'(k);
            cnt = cnt + 3'd1;
          end else begin
            st.ovfSet = 1'b1;
          end
        end
      end
      st.pushCnt = cnt;
    end
  end
endmodule

// File: rtl/winDatapath.sv
module winDatapath
  import fifoWinPkg::*;
#(
  parameter int CH    = 4,
  parameter int DEPTH = 256,
  parameter int CHW   = $clog2(CH),
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  winStrobe_t            st,
  input  logic [CHW-1:0]        chanSel,
  input  logic [31:0]           busWdata,
  input  logic                  rxPushEn,
  input  logic [CHW-1:0]        rxPushChan,
  input  logic [7:0]            rxPushData,
  input  logic [7:0]            rxPushStat,
  input  logic                  txPopEn,
  input  logic [CHW-1:0]        txPopChan,
  output logic [CH-1:0][CW-1:0] rxLevel,
  output logic [CH-1:0][CW-1:0] txLevel,
  output logic [31:0]           busRdata,
  output logic                  busRvalid,
  output logic [7:0]            txPopData,
  output logic [CH-1:0]         txEmpty,
  output logic [CH-1:0]         txOverflow
);
  logic [CH-1:0][3:0][15:0] rxPeek;
  logic [CH-1:0][0:0][7:0]  txPeek;
  logic [3:0][7:0]          txBytes;
  logic [31:0]              rdNext;

  // transmit bytes compacted into push order
  always_comb begin
    for (int j = 0; j < 4; j++) txBytes[j] = busWdata[st.pushLane[j]*8 +: 8];
  end

  for (genvar c = 0; c < CH; c++) begin : g_chan
    logic [2:0] rxPushCnt, rxPopCnt, txPushCnt, txPopCnt;
    logic [0:0][15:0] rxEntry;

    assign rxEntry[0] = {rxPushStat, rxPushData};
    assign rxPushCnt  = (rxPushEn && rxPushChan == CHW'(c) && rxLevel[c] != CW'(DEPTH)) ? 3'd1 : 3'd0;
    assign rxPopCnt   = (st.rdCapture && chanSel == CHW'(c)) ? st.popCnt : 3'd0;
    assign txPushCnt  = (chanSel == CHW'(c)) ? st.pushCnt : 3'd0;
    assign txPopCnt   = (txPopEn && txPopChan == CHW'(c) && txLevel[c] != '0) ? 3'd1 : 3'd0;
    assign txEmpty[c] = txLevel[c] == '0;

    chanFifo #(.W(16), .DEPTH(DEPTH), .NPUSH(1), .NPOP(4), .CW(CW)) u_rx (
      .clk(clk), .rstN(rstN), .pushCnt(rxPushCnt), .pushData(rxEntry),
      .popCnt(rxPopCnt), .peek(rxPeek[c]), .level(rxLevel[c]));

    chanFifo #(.W(8), .DEPTH(DEPTH), .NPUSH(4), .NPOP(1), .CW(CW)) u_tx (
      .clk(clk), .rstN(rstN), .pushCnt(txPushCnt), .pushData(txBytes),
      .popCnt(txPopCnt), .peek(txPeek[c]), .level(txLevel[c]));
  end

  assign txPopData = txPeek[txPopChan][0];

  always_comb begin
    logic [3:0][15:0] head;
    logic [15:0]      lo, hi;
    head   = rxPeek[chanSel];
    rdNext = '0;
    lo     = head[st.laneEntry[0]];
    hi     = head[st.laneEntry[2]];
    if (st.statusView) begin
      if (st.laneLive[0] && st.laneLive[1]) rdNext[15:0]  = {lo[7:0], lo[15:8]};
      if (st.laneLive[2] && st.laneLive[3]) rdNext[31:16] = {hi[7:0], hi[15:8]};
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (st.laneLive[k]) rdNext[k*8 +: 8] = head[st.laneEntry[k]][7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRvalid  <= 1'b0;
      busRdata   <= '0;
      txOverflow <= '0;
    end else begin
      busRvalid <= st.rdCapture;
      if (st.rdCapture) busRdata <= rdNext;
      if (st.ovfSet) txOverflow[chanSel] <= 1'b1;
    end
  end
endmodule

// File: rtl/fifoBurstWindow.sv
module fifoBurstWindow
  import fifoWinPkg::*;
#(
  parameter int CH     = 4,
  parameter int DEPTH  = 256,
  parameter int PAGE_W = 8,
  parameter int CHW    = $clog2(CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWr,
  input  logic [PAGE_W-1:0] busPage,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic              busHit,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  input  logic              rxPushEn,
  input  logic [CHW-1:0]    rxPushChan,
  input  logic [7:0]        rxPushData,
  input  logic [7:0]        rxPushStat,
  input  logic              txPopEn,
  input  logic [CHW-1:0]    txPopChan,
  output logic [7:0]        txPopData,
  output logic [CH-1:0]     txEmpty,
  output logic [CH-1:0]     txOverflow
);
  localparam int CW = $clog2(DEPTH) + 1;

  winStrobe_t            st;
  logic [CHW-1:0]        chanSel;
  logic [CH-1:0][CW-1:0] rxLevel, txLevel;

  winCtrl #(.CH(CH), .DEPTH(DEPTH), .PAGE_W(PAGE_W), .CHW(CHW), .CW(CW)) u_ctrl (
    .busReq(busReq), .busWr(busWr), .busPage(busPage), .busBe(busBe),
    .rxLevel(rxLevel), .txLevel(txLevel), .busHit(busHit),
    .chanSel(chanSel), .st(st));

  winDatapath #(.CH(CH), .DEPTH(DEPTH), .CHW(CHW), .CW(CW)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .chanSel(chanSel), .busWdata(busWdata),
    .rxPushEn(rxPushEn), .rxPushChan(rxPushChan), .rxPushData(rxPushData),
    .rxPushStat(rxPushStat), .txPopEn(txPopEn), .txPopChan(txPopChan),
    .rxLevel(rxLevel), .txLevel(txLevel), .busRdata(busRdata),
    .busRvalid(busRvalid), .txPopData(txPopData), .txEmpty(txEmpty),
    .txOverflow(txOverflow));
endmodule

// File: rtl/winChecker.sv
module winChecker #(
  parameter int CH     = 4,
  parameter int PAGE_W = 8,
  parameter int CHW    = 2,
  parameter int CW     = 9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busReq,
  input logic                  busWr,
  input logic [PAGE_W-1:0]     busPage,
  input logic [3:0]            busBe,
  input logic                  busHit,
  input logic [31:0]           busRdata,
  input logic                  busRvalid,
  input logic [CH-1:0]         txOverflow,
  input logic [CH-1:0][CW-1:0] rxLevel
);
  logic claimedRd, tornStat, outside;
  assign claimedRd = busReq && busHit && !busWr;
  assign tornStat  = busPage[1:0] == 2'b10 &&
                     ((busBe[1] ^ busBe[0]) || (busBe[3] ^ busBe[2]));
  assign outside   = (busPage >> (2 + CHW)) != '0;

  // R1
  no_claim_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && outside) |-> !busHit);
  // R2
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    claimedRd |=> busRvalid);
  // R2
  rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !claimedRd |=> !busRvalid);
  // R5
  torn_status_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimedRd && tornStat) |=> busRdata == 32'h0);
  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimedRd && rxLevel[busPage[2 +: CHW]] == '0) |=> busRdata == 32'h0);
  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((txOverflow & $past(txOverflow)) == $past(txOverflow)));
endmodule

bind fifoBurstWindow winChecker #(.CH(CH), .PAGE_W(PAGE_W), .CHW(CHW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busPage(busPage),
  .busBe(busBe), .busHit(busHit), .busRdata(busRdata), .busRvalid(busRvalid),
  .txOverflow(txOverflow), .rxLevel(rxLevel));

// File: tb/tb_fifoBurstWindow.sv
module tb_fifoBurstWindow;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, busReq, busWr, busHit, busRvalid;
  logic [7:0]  busPage;
  logic [3:0]  busBe, txEmpty, txOverflow;
  logic [31:0] busWdata, busRdata;
  logic        rxPushEn, txPopEn;
  logic [1:0]  rxPushChan, txPopChan;
  logic [7:0]  rxPushData, rxPushStat, txPopData;

  fifoBurstWindow dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busPage(busPage),
    .busBe(busBe), .busWdata(busWdata), .busHit(busHit), .busRdata(busRdata),
    .busRvalid(busRvalid), .rxPushEn(rxPushEn), .rxPushChan(rxPushChan),
    .rxPushData(rxPushData), .rxPushStat(rxPushStat), .txPopEn(txPopEn),
    .txPopChan(txPopChan), .txPopData(txPopData), .txEmpty(txEmpty),
    .txOverflow(txOverflow));

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [15:0] rxQ[4][$];   // {status, data}
  logic [7:0]  txQ[4][$];
  logic [3:0]  ovfModel = 4'h0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pageOf(int ch, int win);
    return {4'b0000, 2'(ch), 2'(win)};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      if (expQ.size() == 0) check(1'b0, "R2 unexpected busRvalid", busRdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdata === e, t, busRdata, e);
      end
    end
  end

  task automatic rxPush(int ch, logic [7:0] d, logic [7:0] s);
    @(negedge clk);
    rxPushEn = 1'b1; rxPushChan = 2'(ch); rxPushData = d; rxPushStat = s;
    if (rxQ[ch].size() < 256) rxQ[ch].push_back({s, d});
    @(posedge clk);
    #1 rxPushEn = 1'b0;
  endtask

  // driver: issues one read and records its expected word
  task automatic busRead(int ch, bit statusWin, logic [3:0] be, string tag);
    logic [31:0] w;
    logic [15:0] e;
    w = '0;
    @(negedge clk);
    busReq = 1'b1; busWr = 1'b0; busBe = be;
    busPage = pageOf(ch, statusWin ? 2 : 1);
    if (statusWin) begin
      if (!((be[1] ^ be[0]) || (be[3] ^ be[2]))) begin
        for (int h = 0; h < 2; h++) begin
          if (be[2*h +: 2] == 2'b11 && rxQ[ch].size() > 0) begin
            e = rxQ[ch].pop_front();
            w[16*h +: 16] = {e[7:0], e[15:8]};
          end
        end
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (be[k] && rxQ[ch].size() > 0) begin
          e = rxQ[ch].pop_front();
          w[8*k +: 8] = e[7:0];
        end
      end
    end
    expQ.push_back(w);
    tagQ.push_back(tag);
    @(posedge clk);
  endtask

  task automatic busWrite(int ch, logic [3:0] be, logic [31:0] data);
    @(negedge clk);
    busReq = 1'b1; busWr = 1'b1; busBe = be; busWdata = data;
    busPage = pageOf(ch, 1);
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        if (txQ[ch].size() < 256) txQ[ch].push_back(data[8*k +: 8]);
        else ovfModel[ch] = 1'b1;
      end
    end
    @(posedge clk);
  endtask

  task automatic busIdle();
    @(negedge clk);
    busReq = 1'b0; busWr = 1'b0;
  endtask

  task automatic hitCheck(bit wr, logic [7:0] page, logic req, bit expHit, string tag);
    @(negedge clk);
    busReq = req; busWr = wr; busPage = page; busBe = 4'hF;
    #1 check(busHit === expHit, tag, {31'b0, busHit}, {31'b0, expHit});
    #1 busReq = 1'b0;
  endtask

  task automatic txDrain(int ch, string tag);
    while (txQ[ch].size() > 0) begin
      logic [7:0] e;
      @(negedge clk);
      txPopEn = 1'b1; txPopChan = 2'(ch);
      e = txQ[ch].pop_front();
      #1 check(txPopData === e, tag, {24'b0, txPopData}, {24'b0, e});
      @(posedge clk);
      #1 txPopEn = 1'b0;
    end
    #1 check(txEmpty[ch] === 1'b1, "R7 txEmpty after drain", {28'b0, txEmpty}, 32'(1 << ch));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN = 1'b0; busReq = 1'b0; busWr = 1'b0; busPage = '0; busBe = '0; busWdata = '0;
    rxPushEn = 1'b0; rxPushChan = '0; rxPushData = '0; rxPushStat = '0;
    txPopEn = 1'b0; txPopChan = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R10 reset state
    check(busRvalid === 1'b0, "R10 busRvalid after reset", {31'b0, busRvalid}, 32'h0);
    check(txEmpty === 4'hF, "R10 txEmpty after reset", {28'b0, txEmpty}, 32'hF);
    check(txOverflow === 4'h0, "R10 txOverflow after reset", {28'b0, txOverflow}, 32'h0);

    // R1 decode
    hitCheck(1'b0, pageOf(0, 1), 1'b1, 1'b1, "R1 transfer read ch0");
    hitCheck(1'b1, pageOf(3, 1), 1'b1, 1'b1, "R1 transfer write ch3");
    hitCheck(1'b0, pageOf(2, 2), 1'b1, 1'b1, "R1 status read ch2");
    hitCheck(1'b1, pageOf(2, 2), 1'b1, 1'b0, "R1 status write unclaimed");
    hitCheck(1'b0, pageOf(1, 0), 1'b1, 1'b0, "R1 window 00 unclaimed");
    hitCheck(1'b0, pageOf(1, 3), 1'b1, 1'b0, "R1 window 11 unclaimed");
    hitCheck(1'b0, 8'h11, 1'b1, 1'b0, "R1 upper bits unclaimed");
    hitCheck(1'b0, pageOf(0, 1), 1'b0, 1'b0, "R1 no request");
    // R1 status-window write leaves transmit FIFO untouched
    @(negedge clk);
    busReq = 1'b1; busWr = 1'b1; busPage = pageOf(2, 2); busBe = 4'hF; busWdata = 32'hDEADBEEF;
    busIdle();
    #1 check(txEmpty === 4'hF, "R1 status write no effect", {28'b0, txEmpty}, 32'hF);

    // R3 packed reads, back-to-back (R2)
    for (int i = 0; i < 12; i++) rxPush(0, 8'(8'h10 + i), 8'(8'hA0 + i));
    busRead(0, 1'b0, 4'hF, "R3 packed full word 1");
    busRead(0, 1'b0, 4'hF, "R2 back-to-back packed word 2");
    busRead(0, 1'b0, 4'b1010, "R3 sparse lanes 1 and 3");
    busRead(0, 1'b0, 4'b0100, "R3 single lane 2");
    busIdle();
    busRead(0, 1'b0, 4'b0001, "R3 last entry lane 0");
    busRead(0, 1'b0, 4'b0000, "R3 no lanes enabled");
    busIdle();

    // R4 / R5 status view
    for (int i = 0; i < 6; i++) rxPush(1, 8'(8'h30 + i), 8'(8'hC0 + i));
    busRead(1, 1'b1, 4'hF, "R4 status full word");
    busRead(1, 1'b1, 4'b0011, "R4 lower half only");
    busRead(1, 1'b1, 4'b1100, "R4 upper half only");
    busRead(1, 1'b1, 4'b0001, "R5 byte read no pop");
    busRead(1, 1'b1, 4'b0111, "R5 torn upper half no pop");
    busRead(1, 1'b1, 4'hF, "R5 entries kept after torn reads");
    busIdle();

    // R6 reads across the empty point
    busRead(2, 1'b0, 4'hF, "R6 empty packed read");
    busIdle();
    rxPush(2, 8'h5A, 8'h61);
    busRead(2, 1'b1, 4'hF, "R6 status read one entry");
    busRead(2, 1'b1, 4'hF, "R6 status read empty");
    busIdle();
    for (int i = 0; i < 3; i++) rxPush(2, 8'(8'h70 + i), 8'h00);
    busRead(2, 1'b0, 4'hF, "R6 packed three of four");
    busIdle();

    // R7 transmit loading
    busWrite(0, 4'hF, 32'h44332211);
    busWrite(0, 4'b0110, 32'hEECCBBAA);
    busWrite(0, 4'b1001, 32'h99000077);
    busIdle();
    txDrain(0, "R7 transmit byte order");

    // R8 overflow at a word boundary
    for (int i = 0; i < 63; i++) busWrite(1, 4'hF, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    busWrite(1, 4'b0011, 32'h0000F1F0);
    busWrite(1, 4'hF, 32'hE3E2E1E0);
    busIdle();
    #1 check(txOverflow === ovfModel, "R8 overflow flag set", {28'b0, txOverflow}, {28'b0, ovfModel});
    txDrain(1, "R8 partial word kept before drop");
    #1 check(txOverflow === 4'b0010, "R8 overflow sticky after drain", {28'b0, txOverflow}, 32'h2);

    // R9 full receive FIFO drained by 64 back-to-back reads
    for (int i = 0; i < 258; i++) rxPush(3, 8'(i * 7), 8'(i));
    for (int i = 0; i < 64; i++) busRead(3, 1'b0, 4'hF, "R9 full drain in order");
    busRead(3, 1'b0, 4'hF, "R9 drained FIFO reads zero");
    busIdle();

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 every read answered", 32'(expQ.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule